// File: doc/BRIEF.md
# Block-Lock Write Protection Controller

This block is the write gatekeeper of a small serial nonvolatile byte memory. A serial front-end decodes each chip-select frame into a command code, an optional byte address and a stream of data bytes. The block collects these into a frame record, and at the end of the frame (the rising edge of the active-low chip select) it decides whether the requested write may proceed. It holds the status register: a write-enable latch, a two-bit protected-region selector and a nonvolatile bit that arms the hardware write-protect pin.

An accepted write starts a self-timed internal cycle, shown as busy for a parameterised number of clock cycles that stands in for the cell programming time. During an array write cycle the block emits the buffered page to the array port one byte per clock, in ascending page offset. A status write takes effect when its cycle ends. A refused write raises a one-cycle deny pulse and commits nothing.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, busy is low and neither grant nor deny is asserted.
- R2: Command codes on `cmd_code` are 1 = set-write-enable, 2 = clear-write-enable, 3 = status write, 4 = array write. At the close of a frame, set-write-enable sets status bit 1 and clear-write-enable clears it. The status byte is: bit 0 busy, bit 1 write-enable latch, bits 3:2 protect selector, bit 7 pin-arm bit, and the other bits read as 0.
- R3: A status or array write with the write-enable latch clear is refused (`wr_deny` for one cycle). Busy stays low and no array byte is written.
- R4: Protect selector 0 locks nothing, 1 locks 0x3000–0x3FFF, 2 locks 0x2000–0x3FFF and 3 locks the whole array. An array write whose address is in the locked range is refused. The write-enable latch is left unchanged by the refusal. Status writes are not affected by the selector.
- R5: With the pin-arm bit at 1 and `wp_n` low, a status write is refused, while array writes follow only R3 and R4.
- R6: With the pin-arm bit at 0, `wp_n` has no effect and status writes are accepted with `wp_n` low.
- R7: With the pin-arm bit at 1, `wp_n` sampled low in any cycle of a status-write frame cancels that write. Once the internal cycle has started, `wp_n` does not affect it.
- R8: Data byte i of an array write goes to page offset (address[4:0] + i) mod 32 within the 32-byte page of the address, and a later byte to the same offset replaces an earlier one. During the cycle the written offsets are emitted on the array port in ascending offset order, starting in the first busy cycle.
- R9: A write starts only at the close of a frame that received at least one data byte and no partial byte (`partial_byte` low at the close). A write frame that does not start raises `wr_deny`.
- R10: An accepted write asserts `wr_grant` for one cycle and busy (status bit 0) for exactly WRITE_CYCLES cycles. When the cycle ends the write-enable latch clears, and a status write loads bits 7 and 3:2 from its data byte while ignoring the other data bits.
- R11: While busy, command, address and byte inputs are ignored, so a clear-write-enable frame during a cycle leaves status bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select framing each command |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_code | input | 3 | Command code (see R2) |
| addr_valid | input | 1 | Byte address present this cycle |
| addr | input | ADDR_W | Byte address of an array write |
| byte_valid | input | 1 | Data byte present this cycle |
| byte_data | input | 8 | Data byte |
| partial_byte | input | 1 | Front-end holds an incomplete byte at frame close |
| status | output | 8 | Status byte (layout in R2) |
| busy | output | 1 | Internal write cycle in progress |
| wr_grant | output | 1 | One-cycle pulse: write accepted and started |
| wr_deny | output | 1 | One-cycle pulse: write frame refused |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | 8 | Array byte data |

## Verification
The bench sends writes just inside and just outside each locked range. A design that decodes the selector wrongly either writes into a locked quarter or refuses a legal address at 0x2FFF or 0x1FFF. It drives a page write that wraps past offset 31 and one that writes more than 32 bytes. Wrong offset arithmetic shows up as bytes at the wrong array address, and a missing overwrite shows up as stale data. It drops the write-protect pin in the middle of a status-write frame and again during the internal cycle. A design that samples the pin only at the close of the frame would accept the first write, and one that keeps watching the pin would lose the second. It also sends frames with a partial byte, frames with no data, and latch commands during a busy cycle. Each of these must leave the status byte exactly as predicted.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_WREN  = 3'd1,
    CMD_WRDI  = 3'd2,
    CMD_WRSR  = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_READ  = 3'd5
  } wpc_cmd_e;

  localparam int STAT_W = 8;
endpackage

// File: rtl/wpc_region_chk.sv
module wpc_region_chk #(
  parameter int ADDR_W = 14
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  // upper quarter / upper half / whole array, keyed on the top address bits
  always_comb begin
    case (bp)
      2'd0:    locked = 1'b0;
      2'd1:    locked = &addr[ADDR_W-1 -: 2];
      2'd2:    locked = addr[ADDR_W-1];
      default: locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpc_cycle_timer.sv
module wpc_cycle_timer #(
  parameter int CYCLES = 1250000,
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          done
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign done = busy_q && (cnt_q == CW'(CYCLES - 1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign cnt  = cnt_q;

  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CW'(CYCLES - 1)));
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
endmodule

// File: rtl/wpc_page_buf.sv
module wpc_page_buf #(
  parameter int PAGE_BYTES = 32,
  localparam int OW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [OW-1:0] wr_off,
  input  logic [7:0]    wr_data,
  input  logic [OW-1:0] rd_off,
  output logic [7:0]    rd_data,
  output logic          rd_vld
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_off == OW'(g));

    always_ff @(posedge clk) begin
      if (hit) data_q[g] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q[g] <= 1'b0;
      else if (clear) vld_q[g] <= 1'b0;
      else if (hit)   vld_q[g] <= 1'b1;
    end
  end

  assign rd_data = data_q[rd_off];
  assign rd_vld  = vld_q[rd_off];
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_code,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              partial_byte,
  output logic [7:0]        status,
  output logic              busy,
  output logic              wr_grant,
  output logic              wr_deny,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int CW = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

  // frame record
  logic              cs_q, open_q, open_d;
  wpc_cmd_e          cmd_q, cmd_d;
  logic [ADDR_W-1:0] fa_q, fa_d;
  logic              has_a_q, has_a_d;
  logic [OW-1:0]     off_q, off_d;
  logic              got_q, got_d;
  logic              wplo_q, wplo_d;
  logic [7:0]        sr_q, sr_d;
  // status and result
  logic              wel_q, wel_d, wpen_q, wpen_d;
  logic [1:0]        bp_q, bp_d;
  logic              gnt_q, gnt_d, dny_q, dny_d, ksr_q, ksr_d;

  logic              cs_fall, cs_rise, take, locked, start, clr, bwr;
  logic              t_busy, t_done, rd_vld;
  logic [CW-1:0]     t_cnt;
  logic [7:0]        rd_data;
  wpc_cmd_e          cmd_now;

  assign cs_fall = !cs_n && cs_q;
  assign cs_rise = cs_n && !cs_q;
  assign take    = !cs_n && (open_q || cs_fall) && !t_busy;
  assign cmd_now = wpc_cmd_e'(cmd_code);

  wpc_region_chk #(.ADDR_W(ADDR_W)) u_region (
    .bp(bp_q), .addr(fa_q), .locked(locked));

  wpc_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(t_busy), .cnt(t_cnt), .done(t_done));

  wpc_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk(clk), .rst_n(rst_n), .clear(clr), .wr_en(bwr), .wr_off(off_q),
    .wr_data(byte_data), .rd_off(t_cnt[OW-1:0]), .rd_data(rd_data), .rd_vld(rd_vld));

  always_comb begin
    open_d = open_q;  cmd_d = cmd_q;  fa_d = fa_q;  has_a_d = has_a_q;
    off_d  = off_q;   got_d = got_q;  wplo_d = wplo_q;  sr_d = sr_q;
    wel_d  = wel_q;   wpen_d = wpen_q;  bp_d = bp_q;  ksr_d = ksr_q;
    gnt_d  = 1'b0;    dny_d = 1'b0;   start = 1'b0;  clr = 1'b0;  bwr = 1'b0;

    if (cs_fall) begin
      open_d = 1'b1;  cmd_d = CMD_NONE;  has_a_d = 1'b0;
      got_d  = 1'b0;  wplo_d = 1'b0;
    end
    if (!cs_n && !wp_n) wplo_d = 1'b1;
    if (take && cmd_valid) begin
      cmd_d = cmd_now;
      if (cmd_now == CMD_WRITE) clr = 1'b1;
    end
    if (take && addr_valid && cmd_q == CMD_WRITE) begin
      fa_d = addr;  off_d = addr[OW-1:0];  has_a_d = 1'b1;
    end
    if (take && byte_valid) begin
      if (cmd_q == CMD_WRITE && has_a_q) begin
        bwr = 1'b1;  off_d = off_q + 1'b1;  got_d = 1'b1;
      end else if (cmd_q == CMD_WRSR) begin
        sr_d = byte_data;  got_d = 1'b1;
      end
    end

    if (cs_rise) begin
      open_d = 1'b0;
      if (open_q && !t_busy) begin
        case (cmd_q)
          CMD_WREN: wel_d = 1'b1;
          CMD_WRDI: wel_d = 1'b0;
          CMD_WRITE, CMD_WRSR: begin
            if (wel_q && got_q && !partial_byte &&
                ((cmd_q == CMD_WRITE) ? !locked : !(wpen_q && wplo_q))) begin
              start = 1'b1;  gnt_d = 1'b1;  ksr_d = (cmd_q == CMD_WRSR);
            end else begin
              dny_d = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end

    if (t_done) begin
      wel_d = 1'b0;
      if (ksr_q) begin
        bp_d = sr_q[3:2];  wpen_d = sr_q[7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;  open_q <= 1'b0;  cmd_q <= CMD_NONE;  fa_q <= '0;
      has_a_q <= 1'b0;  off_q <= '0;  got_q <= 1'b0;  wplo_q <= 1'b0;
      sr_q <= '0;  wel_q <= 1'b0;  wpen_q <= 1'b0;  bp_q <= '0;
      gnt_q <= 1'b0;  dny_q <= 1'b0;  ksr_q <= 1'b0;
    end else begin
      cs_q <= cs_n;  open_q <= open_d;  cmd_q <= cmd_d;  fa_q <= fa_d;
      has_a_q <= has_a_d;  off_q <= off_d;  got_q <= got_d;  wplo_q <= wplo_d;
      sr_q <= sr_d;  wel_q <= wel_d;  wpen_q <= wpen_d;  bp_q <= bp_d;
      gnt_q <= gnt_d;  dny_q <= dny_d;  ksr_q <= ksr_d;
    end
  end

  assign status    = {wpen_q, 3'b000, bp_q, wel_q, t_busy};
  assign busy      = t_busy;
  assign wr_grant  = gnt_q;
  assign wr_deny   = dny_q;
  assign arr_we    = t_busy && !ksr_q && (t_cnt < CW'(PAGE_BYTES)) && rd_vld;
  assign arr_addr  = {fa_q[ADDR_W-1:OW], t_cnt[OW-1:0]};
  assign arr_wdata = rd_data;

  a_r3_grant_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> $past(wel_q));
  a_r10_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> busy);
  a_r10_wel_clear_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status[1]);
  a_r8_commit_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  a_r9_grant_deny_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_grant && wr_deny));
  a_r4_no_locked_commit: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !locked);
  a_r11_status_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(status[7:2])));
endmodule

// File: tb/wprot_ctrl_tb_top.sv
module wprot_ctrl_tb_top;
  localparam int AW  = 14;
  localparam int CYC = 40;
  localparam int WD  = 150000;

  logic clk = 1'b0;
  logic rst_n, cs_n, wp_n, cmd_valid, addr_valid, byte_valid, partial_byte;
  logic [2:0] cmd_code;
  logic [AW-1:0] addr, arr_addr;
  logic [7:0] byte_data, status, arr_wdata;
  logic busy, wr_grant, wr_deny, arr_we;

  int checks = 0;
  int fails  = 0;
  logic [21:0] exp_q [$];
  logic last_g, last_d;

  always #2 clk = ~clk;

  wprot_ctrl #(.ADDR_W(AW), .PAGE_BYTES(32), .WRITE_CYCLES(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .addr_valid(addr_valid),
    .addr(addr), .byte_valid(byte_valid), .byte_data(byte_data),
    .partial_byte(partial_byte), .status(status), .busy(busy),
    .wr_grant(wr_grant), .wr_deny(wr_deny), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pop expected array writes as they appear
  always @(negedge clk) begin
    if (rst_n === 1'b1 && arr_we === 1'b1) begin
      if (exp_q.size() == 0) chk("R8", "unexpected array write", {10'd0, arr_addr, arr_wdata}, 32'hFFFFFFFF);
      else chk("R8", "array write addr/data", {10'd0, arr_addr, arr_wdata}, {10'd0, exp_q.pop_front()});
    end
  end

  task automatic frm_open();
    cs_n = 1'b0; @(negedge clk);
  endtask
  task automatic put_cmd(logic [2:0] c);
    cmd_valid = 1'b1; cmd_code = c; @(negedge clk); cmd_valid = 1'b0; @(negedge clk);
  endtask
  task automatic put_addr(logic [AW-1:0] a);
    addr_valid = 1'b1; addr = a; @(negedge clk); addr_valid = 1'b0; @(negedge clk);
  endtask
  task automatic put_byte(logic [7:0] b);
    byte_valid = 1'b1; byte_data = b; @(negedge clk); byte_valid = 1'b0; @(negedge clk);
  endtask
  task automatic frm_close(logic part);
    partial_byte = part; cs_n = 1'b1; @(negedge clk);
    partial_byte = 1'b0; last_g = wr_grant; last_d = wr_deny;
  endtask
  task automatic simple(logic [2:0] c);
    frm_open(); put_cmd(c); frm_close(1'b0); @(negedge clk);
  endtask
  task automatic wait_idle(string req, logic check_len);
    int n = 0;
    while (busy === 1'b1) begin n++; @(negedge clk); end
    if (check_len) chk(req, "busy length", n, CYC);
    chk("R8", "scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic do_write(string req, logic [AW-1:0] a, int nb, logic [7:0] seed,
                          logic part, logic exp_g, logic wait_end);
    logic [7:0] pb [32];
    bit pv [32];
    for (int o = 0; o < 32; o++) pv[o] = 1'b0;
    frm_open(); put_cmd(3'd4); put_addr(a);
    for (int i = 0; i < nb; i++) begin
      int o = (a[4:0] + i) % 32;
      pb[o] = seed + 8'(i); pv[o] = 1'b1;
      put_byte(seed + 8'(i));
    end
    if (exp_g)
      for (int o = 0; o < 32; o++)
        if (pv[o]) exp_q.push_back({a[AW-1:5], 5'(o), pb[o]});
    frm_close(part);
    chk(req, "write grant", last_g, exp_g);
    chk(req, "write deny", last_d, !exp_g);
    if (!exp_g) chk(req, "busy after deny", busy, 1'b0);
    if (wait_end) wait_idle("R10", exp_g);
  endtask

  task automatic do_wrsr(string req, logic [7:0] d, logic exp_g, logic drop_wp);
    frm_open(); put_cmd(3'd3);
    if (drop_wp) wp_n = 1'b0;
    put_byte(d);
    if (drop_wp) wp_n = 1'b1;
    frm_close(1'b0);
    chk(req, "status write grant", last_g, exp_g);
    chk(req, "status write deny", last_d, !exp_g);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wp_n = 1'b1; cmd_valid = 1'b0; cmd_code = '0;
    addr_valid = 1'b0; addr = '0; byte_valid = 1'b0; byte_data = '0; partial_byte = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "status", status, 8'h00);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "grant/deny", {wr_grant, wr_deny}, 2'b00);
    // R2 latch commands
    simple(3'd1); chk("R2", "status after set", status, 8'h02);
    simple(3'd2); chk("R2", "status after clear", status, 8'h00);
    // R3 no latch
    do_write("R3", 14'h0040, 2, 8'h55, 1'b0, 1'b0, 1'b1);
    chk("R3", "status", status, 8'h00);
    // plain page write, latch cleared at end
    simple(3'd1);
    do_write("R8", 14'h0105, 3, 8'hA0, 1'b0, 1'b1, 1'b1);
    chk("R10", "latch cleared at end", status, 8'h00);
    // R8 wrap and overwrite
    simple(3'd1);
    do_write("R8", 14'h011E, 4, 8'h10, 1'b0, 1'b1, 1'b1);
    simple(3'd1);
    do_write("R8", 14'h0200, 34, 8'h40, 1'b0, 1'b1, 1'b1);
    // R10 status write: 0x47 -> selector 1, other bits dropped
    simple(3'd1);
    do_wrsr("R10", 8'h47, 1'b1, 1'b0);
    chk("R10", "status during cycle", status, 8'h03);
    wait_idle("R10", 1'b1);
    chk("R10", "status after write", status, 8'h04);
    // R4 selector 1
    simple(3'd1);
    do_write("R4", 14'h3000, 1, 8'h01, 1'b0, 1'b0, 1'b1);
    chk("R4", "latch kept after refusal", status, 8'h06);
    do_write("R4", 14'h2FFF, 1, 8'h02, 1'b0, 1'b1, 1'b1);
    // selector 2
    simple(3'd1); do_wrsr("R4", 8'h08, 1'b1, 1'b0); wait_idle("R10", 1'b0);
    simple(3'd1);
    do_write("R4", 14'h2000, 1, 8'h03, 1'b0, 1'b0, 1'b1);
    do_write("R4", 14'h1FFF, 1, 8'h04, 1'b0, 1'b1, 1'b1);
    // selector 3, status write still allowed
    simple(3'd1); do_wrsr("R4", 8'h0C, 1'b1, 1'b0); wait_idle("R10", 1'b0);
    simple(3'd1);
    do_write("R4", 14'h0000, 1, 8'h05, 1'b0, 1'b0, 1'b1);
    do_wrsr("R4", 8'h00, 1'b1, 1'b0); wait_idle("R10", 1'b0);
    chk("R4", "selector cleared", status, 8'h00);
    // R6 pin ignored while unarmed
    wp_n = 1'b0;
    simple(3'd1); do_wrsr("R6", 8'h80, 1'b1, 1'b0); wait_idle("R10", 1'b0);
    chk("R6", "armed", status, 8'h80);
    // R5 pin low and armed
    simple(3'd1); do_wrsr("R5", 8'h00, 1'b0, 1'b0);
    chk("R5", "status unchanged", status, 8'h82);
    do_write("R5", 14'h0000, 1, 8'h06, 1'b0, 1'b1, 1'b1);
    // R7 pin drop mid-frame cancels; drop during cycle does not
    wp_n = 1'b1;
    simple(3'd1); do_wrsr("R7", 8'h84, 1'b0, 1'b1);
    chk("R7", "status after cancel", status, 8'h82);
    do_wrsr("R7", 8'h84, 1'b1, 1'b0);
    wp_n = 1'b0;
    wait_idle("R7", 1'b1);
    wp_n = 1'b1;
    chk("R7", "status after started write", status, 8'h84);
    simple(3'd1); do_wrsr("R7", 8'h00, 1'b1, 1'b0); wait_idle("R10", 1'b0);
    // R9 partial byte and empty frame
    simple(3'd1);
    do_write("R9", 14'h0300, 2, 8'h70, 1'b1, 1'b0, 1'b1);
    do_write("R9", 14'h0300, 0, 8'h70, 1'b0, 1'b0, 1'b1);
    chk("R9", "status", status, 8'h02);
    // R11 clear-latch frame during cycle is ignored
    do_write("R11", 14'h0400, 1, 8'h99, 1'b0, 1'b1, 1'b0);
    simple(3'd2);
    chk("R11", "status during cycle", status, 8'h03);
    wait_idle("R11", 1'b0);
    chk("R11", "status at end", status, 8'h00);
    finish_up();
  end
endmodule